// File: doc/BRIEF.md
# Direct-Mapped Cache Controller with Bypass and Invalidate

This block sits between a processor memory port and a main-memory port. It serves 16-bit word accesses at 22-bit physical byte addresses from a small direct-mapped store of one-word lines. Read misses are fetched from memory and allocated. Writes always travel to memory, because the cache is write-through with no allocation on a write miss. A cacheable write that hits also refreshes the cached word.

Three conditions each mark an access as uncached:
- the address falls in the I/O page, the top 8 Kbytes of the space;
- the access carries the no-cache flag from the active page descriptor;
- the enable bit of the control register is cleared.

An uncached access goes to memory and never uses the store. If its address matches a valid line, that line is invalidated, so no stale copy survives.

Every completed access shifts its hit outcome into a six-bit history register. The controller is a four-state machine:
- `S_IDLE` accepts a request (transition *accept*).
- `S_LOOK` reads the tag and valid bit. It goes to `S_REPLY` on a cacheable read hit (*serve*). Otherwise it goes to `S_BUS` (*forward*).
- `S_BUS` holds the memory request until it is acknowledged (*complete*).
- `S_REPLY` gives a one-cycle acknowledge to the processor and returns to `S_IDLE` (*release*).

Top module: `cache_ctl`

## Requirements
- R1: A request is taken while `cpu_req` is high in the idle state. Each access ends with exactly one cycle of `cpu_ack`, and `cpu_rdata` and `cpu_hit` are valid in that cycle.
- R2: A cacheable read that misses makes one memory read at the same address. It returns the memory word with `cpu_hit` = 0 and allocates the line.
- R3: A cacheable read that hits returns the cached word with `cpu_hit` = 1 and makes no memory transaction, even if memory has changed since the line was filled.
- R4: The line index is address bits 8:1 and the tag is bits 21:9. A fill at an index replaces the line held there under another tag.
- R5: An access with `cpu_nocache` = 1 always makes a memory transaction, reports `cpu_hit` = 0 and allocates nothing.
- R6: An uncached read or write whose address matches a valid line invalidates that line, so the next cacheable read of that address misses.
- R7: Every write makes one memory write with the request's address and data. A cacheable write hit reports `cpu_hit` = 1 and updates the cached word, which later read hits return.
- R8: A write miss allocates nothing and leaves the line at that index intact.
- R9: An address with bits 21:13 all ones is never allocated, always goes to memory and reports `cpu_hit` = 0. An address just below that page is cached normally.
- R10: Reset clears every valid bit, sets the enable bit to 1, clears the history and drops `cpu_ack` and `mem_req`.
- R11: A cycle with `cfg_wr` = 1 loads `cfg_enable` into the enable bit. While the bit is 0, every access is treated as uncached.
- R12: In the cycle after each `cpu_ack`, `hm_hist` equals its old bits 4:0 with that access's `cpu_hit` shifted into bit 0 (1 = hit).
- R13: `mem_req` stays high with a stable `mem_addr` until `mem_ack`, and each miss, write or uncached access makes exactly one memory transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the enable bit |
| cfg_enable | input | 1 | New enable value |
| cpu_req | input | 1 | Access request, held until acknowledged |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 22 | Physical byte address |
| cpu_wdata | input | 16 | Write data |
| cpu_nocache | input | 1 | Page-descriptor cache bypass for this access |
| cpu_ack | output | 1 | One-cycle completion strobe |
| cpu_rdata | output | 16 | Read data, valid with `cpu_ack` |
| cpu_hit | output | 1 | Served by a cache hit, valid with `cpu_ack` |
| hm_hist | output | 6 | Hit history of the last six accesses, newest in bit 0 |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 22 | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 16 | Memory read data, valid with `mem_ack` |

## Verification
The bench's memory returns a word built from the address and a "generation" value. Raising the generation between accesses imitates an outside writer. A hit then returns the old word and any memory access returns the new one, which shows where each read was served from.

The access streams are:
- repeated reads, to show allocation;
- same-index different-tag reads, to show replacement;
- write hits and write misses, to show update versus no allocation;
- each of the three uncached sources applied to a resident line, then re-read, to show invalidation and not merely bypass.

Addresses at the top of the I/O page and one word below it separate the page decode from ordinary caching. A reset with caching disabled, followed by a run of hits, shows the reset state and the history shifting.

// File: rtl/cache_pkg.sv
package cache_pkg;
    localparam int ADDR_W = 22;
    localparam int DATA_W = 16;
    localparam int IDX_W  = 8;
    localparam int IO_W   = 9;
    localparam int HIST_W = 6;

    typedef enum logic [1:0] {
        S_IDLE,
        S_LOOK,
        S_BUS,
        S_REPLY
    } cstate_t;
endpackage

// File: rtl/cache_classify.sv
module cache_classify #(
    parameter int ADDR_W = cache_pkg::ADDR_W,
    parameter int IO_W   = cache_pkg::IO_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              nocache,
    input  logic              enable,
    output logic              cacheable
);
    logic io_page;

    // I/O page: the top IO_W address bits are all ones
    assign io_page   = &addr[ADDR_W-1 -: IO_W];
    assign cacheable = enable && !nocache && !io_page;
endmodule

// File: rtl/cache_store.sv
module cache_store #(
    parameter int IDX_W  = cache_pkg::IDX_W,
    parameter int TAG_W  = 13,
    parameter int DATA_W = cache_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              inv_en,
    input  logic [IDX_W-1:0]  inv_idx
);
    localparam int LINES = 1 << IDX_W;

    logic              valid_q [LINES];
    logic [TAG_W-1:0]  tag_q   [LINES];
    logic [DATA_W-1:0] data_q  [LINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                valid_q[i] <= 1'b0;
            end
        end else begin
            if (wr_en) begin
                valid_q[wr_idx] <= 1'b1;
            end
            if (inv_en) begin
                valid_q[inv_idx] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_data;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_data  = data_q[rd_idx];
endmodule

// File: rtl/cache_hist.sv
module cache_hist #(
    parameter int HIST_W = cache_pkg::HIST_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [HIST_W-1:0] hist
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (shift_en) begin
            hist <= {hist[HIST_W-2:0], bit_in};
        end
    end
endmodule

// File: rtl/cache_ctl.sv
module cache_ctl
    import cache_pkg::*;
#(
    parameter int AW = cache_pkg::ADDR_W,
    parameter int DW = cache_pkg::DATA_W,
    parameter int IW = cache_pkg::IDX_W,
    parameter int HW = cache_pkg::HIST_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic          cfg_enable,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          cpu_nocache,
    output logic          cpu_ack,
    output logic [DW-1:0] cpu_rdata,
    output logic          cpu_hit,
    output logic [HW-1:0] hm_hist,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata
);
    localparam int TW = AW - IW - 1;

    cstate_t state_q, state_d;

    logic          en_q;
    logic          req_we, req_nc;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic          cache_q, hit_q;
    logic [DW-1:0] rdata_q;

    logic          cacheable;
    logic          rd_valid;
    logic [TW-1:0] rd_tag;
    logic [DW-1:0] rd_data;
    logic          lk_hit;
    logic          st_wr, st_inv;
    logic [DW-1:0] st_wdata;
    logic [IW-1:0] line_idx;
    logic [TW-1:0] line_tag;

    assign line_idx = req_addr[IW:1];
    assign line_tag = req_addr[AW-1:IW+1];
    assign lk_hit   = rd_valid && (rd_tag == line_tag);

    cache_classify #(.ADDR_W(AW), .IO_W(cache_pkg::IO_W)) u_class (
        .addr      (req_addr),
        .nocache   (req_nc),
        .enable    (en_q),
        .cacheable (cacheable)
    );

    cache_store #(.IDX_W(IW), .TAG_W(TW), .DATA_W(DW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (line_idx),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_data  (rd_data),
        .wr_en    (st_wr),
        .wr_idx   (line_idx),
        .wr_tag   (line_tag),
        .wr_data  (st_wdata),
        .inv_en   (st_inv),
        .inv_idx  (line_idx)
    );

    cache_hist #(.HIST_W(HW)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (state_q == S_REPLY),
        .bit_in   (hit_q),
        .hist     (hm_hist)
    );

    // control register: caching on after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b1;
        end else if (cfg_wr) begin
            en_q <= cfg_enable;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: accept, serve, forward, complete, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (cpu_req) state_d = S_LOOK;
            S_LOOK:  state_d = (!req_we && cacheable && lk_hit) ? S_REPLY : S_BUS;
            S_BUS:   if (mem_ack) state_d = S_REPLY;
            S_REPLY: state_d = S_IDLE;
        endcase
    end

    // request capture and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_we    <= 1'b0;
            req_nc    <= 1'b0;
            req_addr  <= '0;
            req_wdata <= '0;
            cache_q   <= 1'b0;
            hit_q     <= 1'b0;
            rdata_q   <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (cpu_req) begin
                        req_we    <= cpu_we;
                        req_nc    <= cpu_nocache;
                        req_addr  <= cpu_addr;
                        req_wdata <= cpu_wdata;
                        hit_q     <= 1'b0;
                    end
                end
                S_LOOK: begin
                    cache_q <= cacheable;
                    hit_q   <= cacheable && lk_hit;
                    if (!req_we && cacheable && lk_hit) begin
                        rdata_q <= rd_data;
                    end
                end
                S_BUS: begin
                    if (mem_ack && !req_we) begin
                        rdata_q <= mem_rdata;
                    end
                end
                S_REPLY: ;
            endcase
        end
    end

    // outputs and store control
    always_comb begin
        st_wr    = 1'b0;
        st_inv   = 1'b0;
        st_wdata = mem_rdata;
        mem_req  = 1'b0;
        cpu_ack  = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_LOOK: begin
                st_wdata = req_wdata;
                st_wr    = cacheable && lk_hit && req_we;
                st_inv   = !cacheable && lk_hit;
            end
            S_BUS: begin
                mem_req = 1'b1;
                st_wr   = mem_ack && !req_we && cache_q;
            end
            S_REPLY: cpu_ack = 1'b1;
        endcase
    end

    assign cpu_rdata = rdata_q;
    assign cpu_hit   = hit_q;
    assign mem_we    = req_we;
    assign mem_addr  = req_addr;
    assign mem_wdata = req_wdata;
endmodule

// File: rtl/cache_ctl_chk.sv
module cache_ctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_ack,
    input logic        cpu_hit,
    input logic [5:0]  hm_hist,
    input logic        mem_req,
    input logic        mem_ack,
    input logic [21:0] mem_addr,
    input logic        req_we,
    input logic        req_nc,
    input logic [21:0] req_addr,
    input logic        en_q
);
    logic bus_seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_seen <= 1'b0;
        end else if (cpu_ack) begin
            bus_seen <= 1'b0;
        end else if (mem_req && mem_ack) begin
            bus_seen <= 1'b1;
        end
    end

    p_ack_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack);

    p_rdhit_nobus_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && cpu_hit && !req_we) |-> !bus_seen);

    p_bypass_nohit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && req_nc) |-> !cpu_hit);

    p_write_through_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && req_we) |-> bus_seen);

    p_io_nohit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && (&req_addr[21:13])) |-> !cpu_hit);

    p_disabled_nohit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && !en_q) |-> !cpu_hit);

    p_hist_shift_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> (hm_hist == {$past(hm_hist[4:0]), $past(cpu_hit)}));

    p_mem_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
endmodule

bind cache_ctl cache_ctl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_ack  (cpu_ack),
    .cpu_hit  (cpu_hit),
    .hm_hist  (hm_hist),
    .mem_req  (mem_req),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .req_we   (req_we),
    .req_nc   (req_nc),
    .req_addr (req_addr),
    .en_q     (en_q)
);

// File: tb/tb_cache_ctl.sv
module tb_cache_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_enable = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_nocache = 1'b0;
    logic [21:0] cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic        cpu_ack, cpu_hit;
    logic [15:0] cpu_rdata;
    logic [5:0]  hm_hist;
    logic        mem_req, mem_we;
    logic [21:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata;
    logic [15:0] gen = '0;

    int checks = 0, fails = 0, cycles = 0, bus_cnt = 0;
    bit done = 0;
    logic [21:0] lw_addr;
    logic [15:0] lw_data;

    always #5 clk = ~clk;

    cache_ctl dut (.*);

    // memory model: word depends on address and an outside-writer generation
    assign mem_rdata = mem_addr[16:1] ^ gen;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && mem_ack) begin
                bus_cnt <= bus_cnt + 1;
                if (mem_we) begin
                    lw_addr <= mem_addr;
                    lw_data <= mem_wdata;
                end
            end
        end
    end

    typedef struct packed {
        logic        we;
        logic        nc;
        logic        en;
        logic [15:0] g;
        logic [21:0] addr;
        logic [15:0] wdata;
        logic        hit;
        logic        bus;
        logic        lit;
        logic [15:0] dat;
        logic [23:0] rq;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b1,16'h0000,22'h000100,16'h0000,1'b0,1'b1,1'b0,16'h0000,"R2 "},
        '{1'b0,1'b0,1'b1,16'h0000,22'h000100,16'h0000,1'b1,1'b0,1'b0,16'h0000,"R3 "},
        '{1'b0,1'b0,1'b1,16'h1000,22'h000100,16'h0000,1'b1,1'b0,1'b1,16'h0080,"R3 "},
        '{1'b0,1'b1,1'b1,16'h1000,22'h000100,16'h0000,1'b0,1'b1,1'b0,16'h0000,"R5 "},
        '{1'b0,1'b0,1'b1,16'h1000,22'h000100,16'h0000,1'b0,1'b1,1'b0,16'h0000,"R6 "},
        '{1'b1,1'b0,1'b1,16'h1000,22'h000100,16'hBEEF,1'b1,1'b1,1'b0,16'h0000,"R7 "},
        '{1'b0,1'b0,1'b1,16'h1000,22'h000100,16'h0000,1'b1,1'b0,1'b1,16'hBEEF,"R7 "},
        '{1'b1,1'b0,1'b1,16'h1000,22'h000300,16'hCAFE,1'b0,1'b1,1'b0,16'h0000,"R8 "},
        '{1'b0,1'b0,1'b1,16'h1000,22'h000100,16'h0000,1'b1,1'b0,1'b1,16'hBEEF,"R8 "},
        '{1'b0,1'b0,1'b1,16'h1000,22'h000300,16'h0000,1'b0,1'b1,1'b0,16'h0000,"R4 "},
        '{1'b0,1'b0,1'b1,16'h1000,22'h000100,16'h0000,1'b0,1'b1,1'b0,16'h0000,"R4 "},
        '{1'b0,1'b0,1'b1,16'h1000,22'h3FFF00,16'h0000,1'b0,1'b1,1'b0,16'h0000,"R9 "},
        '{1'b0,1'b0,1'b1,16'h1000,22'h3FFF00,16'h0000,1'b0,1'b1,1'b0,16'h0000,"R9 "},
        '{1'b0,1'b0,1'b0,16'h1000,22'h000100,16'h0000,1'b0,1'b1,1'b0,16'h0000,"R11"},
        '{1'b0,1'b0,1'b1,16'h1000,22'h000100,16'h0000,1'b0,1'b1,1'b0,16'h0000,"R6 "},
        '{1'b0,1'b0,1'b1,16'h1000,22'h000100,16'h0000,1'b1,1'b0,1'b0,16'h0000,"R3 "},
        '{1'b1,1'b1,1'b1,16'h1000,22'h000100,16'h1234,1'b0,1'b1,1'b0,16'h0000,"R6 "},
        '{1'b0,1'b0,1'b1,16'h1000,22'h000100,16'h0000,1'b0,1'b1,1'b0,16'h0000,"R6 "},
        '{1'b0,1'b0,1'b1,16'h1000,22'h3FDFFE,16'h0000,1'b0,1'b1,1'b0,16'h0000,"R9 "},
        '{1'b0,1'b0,1'b1,16'h1000,22'h3FDFFE,16'h0000,1'b1,1'b0,1'b0,16'h0000,"R9 "}
    };

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic set_enable(input logic v);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_enable = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    logic [15:0] a_data;
    logic        a_hit;
    int          a_bus;

    task automatic access(input logic we, input logic nc, input logic [21:0] addr,
                          input logic [15:0] wd);
        int b0;
        @(negedge clk);
        b0 = bus_cnt;
        cpu_req = 1'b1; cpu_we = we; cpu_nocache = nc;
        cpu_addr = addr; cpu_wdata = wd;
        do @(negedge clk); while (!cpu_ack);
        a_data = cpu_rdata;
        a_hit  = cpu_hit;
        a_bus  = bus_cnt - b0;
        cpu_req = 1'b0;
        @(negedge clk);
        chk(cpu_ack == 1'b0, "R1", "ack one cycle", 32'(cpu_ack), 32'd0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic cur_en;
        logic [15:0] exp_d;
        cur_en = 1'b1;
        repeat (3) @(negedge clk);
        chk(cpu_ack == 1'b0 && mem_req == 1'b0, "R10", "idle after reset",
            32'({cpu_ack, mem_req}), 32'd0);
        chk(hm_hist == 6'd0, "R10", "history after reset", 32'(hm_hist), 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].en != cur_en) begin
                set_enable(VECS[i].en);
                cur_en = VECS[i].en;
            end
            gen = VECS[i].g;
            access(VECS[i].we, VECS[i].nc, VECS[i].addr, VECS[i].wdata);
            chk(a_hit == VECS[i].hit, string'(VECS[i].rq), $sformatf("vec %0d hit", i),
                32'(a_hit), 32'(VECS[i].hit));
            chk(a_bus == int'(VECS[i].bus), string'(VECS[i].rq),
                $sformatf("vec %0d memory transactions", i), 32'(a_bus), 32'(VECS[i].bus));
            if (VECS[i].we) begin
                // R7: write-through with the request's address and data
                chk(lw_addr == VECS[i].addr && lw_data == VECS[i].wdata, "R7",
                    $sformatf("vec %0d memory write", i),
                    {lw_addr[15:0], lw_data}, {VECS[i].addr[15:0], VECS[i].wdata});
            end else begin
                exp_d = VECS[i].lit ? VECS[i].dat : (VECS[i].addr[16:1] ^ VECS[i].g);
                chk(a_data == exp_d, string'(VECS[i].rq), $sformatf("vec %0d data", i),
                    32'(a_data), 32'(exp_d));
            end
        end

        // R10: reset with caching disabled and a resident line
        set_enable(1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(hm_hist == 6'd0, "R10", "history cleared", 32'(hm_hist), 32'd0);
        rst_n = 1'b1;
        access(1'b0, 1'b0, 22'h000100, 16'h0);
        chk(a_hit == 1'b0 && a_bus == 1, "R10", "lines invalid after reset",
            32'({a_hit, a_bus[0]}), 32'b01);
        access(1'b0, 1'b0, 22'h000100, 16'h0);
        chk(a_hit == 1'b1 && a_bus == 0, "R10", "enable set by reset",
            32'({a_hit, a_bus[0]}), 32'b10);
        chk(hm_hist == 6'b000001, "R12", "history miss then hit", 32'(hm_hist), 32'b000001);
        for (int k = 0; k < 4; k++) access(1'b0, 1'b0, 22'h000100, 16'h0);
        chk(hm_hist == 6'b011111, "R12", "history after six", 32'(hm_hist), 32'b011111);
        access(1'b0, 1'b0, 22'h000100, 16'h0);
        chk(hm_hist == 6'b111111, "R12", "oldest outcome dropped", 32'(hm_hist), 32'b111111);

        // R13: one memory transaction for a bypassed read, at the request address
        access(1'b0, 1'b1, 22'h000ABC, 16'h0);
        chk(a_bus == 1 && a_data == (16'h055E ^ gen), "R13", "single bypass read",
            32'({a_bus[0], a_data}), 32'({1'b1, 16'h055E ^ gen}));

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule